// File: doc/BRIEF.md
# Banked GPIO Controller with Combined Interrupt

This block is a register-mapped general purpose I/O controller. It serves a parameterised number of banks, and each bank holds up to 32 pins. Each bank has its own width, set by a parameter. Software reaches the registers through a single-cycle synchronous port. A write takes effect at the clock edge. A read returns data combinationally for the address currently presented.

Each pin can be an output or an input. An output pin either drives its data value or works open-drain, where it only pulls low. Input pins pass through a two-stage synchronizer. The synchronised level feeds the data readback and the interrupt detector. The detector can be set per pin to a single edge, both edges, or an active level of either polarity. Pending events are kept in a status register that software clears by writing ones. A status bit that is also enabled in its bank's enable register raises the one interrupt output that all banks share.

Top module: `gpio_multibank`

## Requirements
- R1: Bank b occupies byte addresses b*0x20 .. b*0x20+0x1C. The word offsets within a bank are fixed:
  - 0x00 open-drain select
  - 0x04 data
  - 0x08 direction
  - 0x0C polarity
  - 0x10 both-edge select
  - 0x14 interrupt enable
  - 0x18 level select
  - 0x1C pending status

  A written value reads back unchanged on the data-free registers. Banks are independent. Addresses with bits [1:0] not zero are neither written nor read, and such a read returns 0.
- R2: After reset every register reads 0 and `irq` is low. Every valid pin is an output driving 0, so its `pin_oe` bit is 1 and its `pin_out` bit is 0.
- R3: A direction bit of 0 makes the pin an output with `pin_oe`=1 and `pin_out` equal to its data bit. A direction bit of 1 makes it an input with `pin_oe`=0.
- R4: An output pin whose open-drain bit is 1 drives `pin_out`=0 with `pin_oe`=1 when its data bit is 0. It releases (`pin_oe`=0) when its data bit is 1.
- R5: Reading the data register returns, for each input pin, its pin level after a two-flop synchronizer, and for each output pin its data latch.
- R6: With level select 0 and both-edge select 0, a pin sets its status bit on a rising edge when its polarity bit is 1, and on a falling edge when the polarity bit is 0. The bit is set at the third clock edge after the pin changes.
- R7: A both-edge bit of 1 sets the status bit on rising and on falling edges, whatever the polarity bit holds.
- R8: In edge mode, writing 1 to a status bit clears it and writing 0 leaves it alone. An edge detected in the same cycle as the clearing write leaves the bit set.
- R9: A level-select bit of 1 makes the status bit follow the synchronised pin level, active high when the polarity bit is 1 and active low when it is 0. Writing 1 does not clear it while the level stays active, and it drops once the level goes inactive.
- R10: `irq` is 1 exactly when, in some bank, a status bit and the matching enable bit are both 1. An enable bit of 0 blocks its pin.
- R11: Register bits at or above a bank's width ignore writes, read as 0, never set status or raise `irq`, and leave `pin_oe` and `pin_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (6) | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | NUM_BANKS*32 | Pin levels from pads, bank b in bits [32b+31:32b] |
| pin_out | output | NUM_BANKS*32 | Pin output values |
| pin_oe | output | NUM_BANKS*32 | Pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench covers the following corner cases:
- **Clear racing an event.** It lines up a clearing write with the exact cycle an edge is detected. A design that let the clear win would lose that event and read the bit as 0.
- **Edge override.** It drives an edge opposite to the configured polarity, once with the both-edge bit clear and once with it set. A detector that ignored the override, or that ignored polarity, would set status in the wrong case.
- **Level mode.** It checks that a clearing write cannot remove an active level and that the bit drops by itself when the level goes away. A design that latched level events like edges would keep the bit set.
- **Narrow bank.** It toggles a pin above the narrow bank's width with every enable set. A design that did not mask unused bits would show stray status bits or a spurious `irq`.

// File: rtl/gpio_multibank_pkg.sv
package gpio_multibank_pkg;

    localparam int LANE_W = 32;

    // Word offset inside a bank window (address bits [4:2]); order is the map
    typedef enum logic [2:0] {
        F_ODRAIN = 3'd0,
        F_DATA   = 3'd1,
        F_DIR    = 3'd2,
        F_POL    = 3'd3,
        F_BOTH   = 3'd4,
        F_ENABLE = 3'd5,
        F_LEVEL  = 3'd6,
        F_STATUS = 3'd7
    } field_e;

    typedef struct packed {
        logic [LANE_W-1:0] odrain;
        logic [LANE_W-1:0] data;
        logic [LANE_W-1:0] dir;
        logic [LANE_W-1:0] pol;
        logic [LANE_W-1:0] both;
        logic [LANE_W-1:0] enable;
        logic [LANE_W-1:0] level;
        logic [LANE_W-1:0] status;
        logic [LANE_W-1:0] prev;
    } bank_state_t;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.stage1 = async_in;
        sy_d.stage2 = sy_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_out = sy_q.stage2;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_multibank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  field_e            wr_field,
    input  logic [LANE_W-1:0] wr_data,
    input  field_e            rd_field,
    output logic [LANE_W-1:0] rd_data,
    input  logic [LANE_W-1:0] pin_in,
    output logic [LANE_W-1:0] pin_out,
    output logic [LANE_W-1:0] pin_oe,
    output logic              irq_req
);
    localparam logic [LANE_W-1:0] VALID = LANE_W'((64'd1 << WIDTH) - 64'd1);

    bank_state_t       st_d, st_q;
    logic [LANE_W-1:0] smp;
    logic [LANE_W-1:0] rise, fall, edge_hit, lvl_active, clr;

    gpio_pin_sync #(.W(LANE_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pin_in),
        .sync_out(smp)
    );

    always_comb begin
        rise       = smp & ~st_q.prev;
        fall       = ~smp & st_q.prev;
        edge_hit   = ((st_q.both & (rise | fall))
                    | (~st_q.both & st_q.pol & rise)
                    | (~st_q.both & ~st_q.pol & fall)) & ~st_q.level & VALID;
        lvl_active = ((st_q.pol & smp) | (~st_q.pol & ~smp)) & st_q.level & VALID;
        clr        = (wr_en && wr_field == F_STATUS) ? (wr_data & VALID) : '0;

        st_d = st_q;
        if (wr_en) begin
            case (wr_field)
                F_ODRAIN: st_d.odrain = wr_data & VALID;
                F_DATA:   st_d.data   = wr_data & VALID;
                F_DIR:    st_d.dir    = wr_data & VALID;
                F_POL:    st_d.pol    = wr_data & VALID;
                F_BOTH:   st_d.both   = wr_data & VALID;
                F_ENABLE: st_d.enable = wr_data & VALID;
                F_LEVEL:  st_d.level  = wr_data & VALID;
                default:  ;
            endcase
        end
        st_d.prev   = smp & VALID;
        st_d.status = (st_q.level & lvl_active)
                    | (~st_q.level & ((st_q.status & ~clr) | edge_hit));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_field)
            F_ODRAIN: rd_data = st_q.odrain;
            F_DATA:   rd_data = ((st_q.dir & smp) | (~st_q.dir & st_q.data)) & VALID;
            F_DIR:    rd_data = st_q.dir;
            F_POL:    rd_data = st_q.pol;
            F_BOTH:   rd_data = st_q.both;
            F_ENABLE: rd_data = st_q.enable;
            F_LEVEL:  rd_data = st_q.level;
            default:  rd_data = st_q.status;
        endcase
    end

    assign pin_oe  = ~st_q.dir & ~(st_q.odrain & st_q.data) & VALID;
    assign pin_out = st_q.data & ~st_q.odrain;
    assign irq_req = |(st_q.status & st_q.enable);

    // A detected edge is always recorded, even against a clearing write (R6, R8)
    p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status & $past(edge_hit)) == $past(edge_hit));

    // A clearing write with no fresh edge empties the bit (R8)
    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status & $past(clr & ~st_q.level & ~edge_hit)) == '0);

    // Level-mode status tracks the active level of the previous cycle (R9)
    p_level_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status ^ $past(lvl_active)) & $past(st_q.level)) == '0);

    // Push-pull pins show the value just written to the data register (R3)
    p_data_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_field == F_DATA) |->
            ((pin_out ^ $past(wr_data)) & ~st_q.odrain & VALID) == '0);
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_multibank_pkg::*;
#(
    parameter int                   NUM_BANKS   = 2,
    parameter logic [NUM_BANKS*8-1:0] BANK_WIDTHS = {8'd20, 8'd32},
    localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = BANK_IDX_W + 5,
    localparam int PIN_W      = NUM_BANKS * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              irq
);
    logic [BANK_IDX_W-1:0] bank_sel;
    field_e                field;
    logic                  aligned;
    logic [31:0]           bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_irq;

    assign bank_sel = reg_addr[ADDR_W-1:5];
    assign field    = field_e'(reg_addr[4:2]);
    assign aligned  = (reg_addr[1:0] == 2'b00);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = int'(BANK_WIDTHS[b*8 +: 8]);
        logic hit;
        assign hit = aligned && (bank_sel == BANK_IDX_W'(b));

        gpio_bank #(.WIDTH(BW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && hit),
            .wr_field(field),
            .wr_data (reg_wdata),
            .rd_field(field),
            .rd_data (bank_rd[b]),
            .pin_in  (pin_in[b*LANE_W +: LANE_W]),
            .pin_out (pin_out[b*LANE_W +: LANE_W]),
            .pin_oe  (pin_oe[b*LANE_W +: LANE_W]),
            .irq_req (bank_irq[b])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (aligned && bank_sel == BANK_IDX_W'(b)) reg_rdata = bank_rd[b];
        end
    end

    assign irq = |bank_irq;
endmodule

// File: tb/gpio_multibank_bench.sv
module gpio_multibank_bench;
    import gpio_multibank_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_multibank u_gpio_multibank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // kind: 0 register read, 1 irq, 2 pin_oe, 3 pin_out
    typedef struct {
        int          kind;
        logic [63:0] msk;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = {32'd0, reg_rdata};
                1:       act = {63'd0, irq};
                2:       act = pin_oe;
                default: act = pin_out;
            endcase
            act = act & it.msk;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s act %h exp %h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [5:0] adr(int b, field_e f);
        return 6'(b * 32 + int'(f) * 4);
    endfunction

    task automatic push(int kind, logic [5:0] a, logic [63:0] msk, logic [63:0] exp, string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.kind = kind; it.msk = msk; it.exp = exp & msk; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic rd(int b, field_e f, logic [31:0] exp, string tag);
        push(0, adr(b, f), 64'hFFFF_FFFF, {32'd0, exp}, tag);
    endtask

    task automatic chk_irq(logic exp, string tag);
        push(1, reg_addr, 64'd1, {63'd0, exp}, tag);
    endtask

    task automatic wr(int b, field_e f, logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = adr(b, f); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog act running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset state
        for (int b = 0; b < 2; b++) begin
            for (int f = 0; f < 8; f++) rd(b, field_e'(f), 32'd0, "R2 reset register");
        end
        chk_irq(1'b0, "R2 irq after reset");
        push(2, 6'd0, '1, {12'h000, 20'hFFFFF, 32'hFFFF_FFFF}, "R2 R11 reset oe");
        push(3, 6'd0, '1, 64'd0, "R2 reset out");

        // R1: readback and bank independence, misaligned access
        wr(0, F_POL, 32'hA5A5_1234);
        rd(0, F_POL, 32'hA5A5_1234, "R1 polarity readback");
        rd(1, F_POL, 32'd0, "R1 other bank untouched");
        push(0, adr(0, F_POL) | 6'd1, 64'hFFFF_FFFF, 64'd0, "R1 misaligned read");

        // R3: push-pull outputs and direction
        wr(0, F_DATA, 32'h0000_00F5);
        push(3, 6'd0, 64'hFFFF_FFFF, 64'h0000_00F5, "R3 output follows data");
        wr(0, F_DIR, 32'hFFFF_0000);
        push(2, 6'd0, 64'hFFFF_FFFF, 64'h0000_FFFF, "R3 inputs released");

        // R4: open-drain on the low nibble (data bits 0,2 high; 1,3 low)
        wr(0, F_ODRAIN, 32'h0000_000F);
        push(2, 6'd0, 64'hFFFF_FFFF, 64'h0000_FFFA, "R4 open-drain enables");
        push(3, 6'd0, 64'hFFFF_FFFF, 64'h0000_00F0, "R4 open-drain values");

        // R5: data readback mixes synced inputs and latches
        pin_in[31:16] = 16'hBEEF;
        settle();
        rd(0, F_DATA, 32'hBEEF_00F5, "R5 mixed data readback");
        wr(1, F_DIR, 32'hFFFF_FFFF);
        rd(1, F_DIR, 32'h000F_FFFF, "R11 narrow bank write ignored");
        pin_in[63:32] = 32'h1234_5678;
        settle();
        rd(1, F_DATA, 32'h0004_5678, "R5 R11 narrow bank input read");

        // clean slate for interrupts
        pin_in = '0;
        settle();
        wr(0, F_POL, 32'd0);
        wr(0, F_STATUS, 32'hFFFF_FFFF);
        wr(1, F_STATUS, 32'hFFFF_FFFF);
        rd(0, F_STATUS, 32'd0, "R8 status cleared");
        rd(1, F_STATUS, 32'd0, "R8 status cleared bank1");

        // R6: rising on pin 16, falling on pin 17
        wr(0, F_POL, 32'h0001_0000);
        wr(0, F_ENABLE, 32'h0001_0000);
        pin_in[16] = 1'b1;
        settle();
        rd(0, F_STATUS, 32'h0001_0000, "R6 rising edge latched");
        chk_irq(1'b1, "R10 enabled pending raises irq");
        pin_in[17] = 1'b1;
        settle();
        rd(0, F_STATUS, 32'h0001_0000, "R6 rise ignored in falling mode");
        pin_in[17] = 1'b0;
        settle();
        rd(0, F_STATUS, 32'h0003_0000, "R6 falling edge latched");

        // R8: write-one-to-clear
        wr(0, F_STATUS, 32'h0001_0000);
        rd(0, F_STATUS, 32'h0002_0000, "R8 only written bit cleared");
        chk_irq(1'b0, "R10 disabled pending blocked");
        pin_in[16] = 1'b0;
        settle();
        rd(0, F_STATUS, 32'h0002_0000, "R6 fall ignored in rising mode");

        // R8: clear collides with detection cycle; the event wins
        @(posedge clk); #1 pin_in[16] = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = adr(0, F_STATUS); reg_wdata = 32'h0001_0000;
        @(posedge clk); #1 reg_we = 1'b0;
        rd(0, F_STATUS, 32'h0003_0000, "R8 set wins over clear");
        chk_irq(1'b1, "R10 irq after collision");
        wr(0, F_STATUS, 32'hFFFF_FFFF);
        wr(0, F_ENABLE, 32'd0);
        chk_irq(1'b0, "R10 irq idle");

        // R7: both edges on bank1 pin 3, polarity says falling
        wr(1, F_BOTH, 32'h0000_0008);
        wr(1, F_ENABLE, 32'h0000_0008);
        pin_in[35] = 1'b1;
        settle();
        rd(1, F_STATUS, 32'h0000_0008, "R7 rise with both-edge");
        chk_irq(1'b1, "R10 bank1 drives irq");
        wr(1, F_STATUS, 32'h0000_0008);
        rd(1, F_STATUS, 32'd0, "R8 bank1 clear");
        pin_in[35] = 1'b0;
        settle();
        rd(1, F_STATUS, 32'h0000_0008, "R7 fall with both-edge");

        // R11: pin above bank1 width never interrupts
        wr(1, F_STATUS, 32'hFFFF_FFFF);
        wr(1, F_ENABLE, 32'hFFFF_FFFF);
        rd(1, F_ENABLE, 32'h000F_FFFF, "R11 enable upper bits dropped");
        wr(1, F_BOTH, 32'hFFFF_FFFF);
        pin_in[57] = 1'b1;
        settle();
        pin_in[57] = 1'b0;
        settle();
        rd(1, F_STATUS, 32'd0, "R11 invalid pin no status");
        chk_irq(1'b0, "R11 invalid pin no irq");
        push(2, 6'd0, 64'hFFF0_0000_0000_0000, 64'd0, "R11 invalid pins not driven");

        // R9: level mode on bank1 pin 5
        wr(1, F_BOTH, 32'd0);
        wr(1, F_ENABLE, 32'h0000_0020);
        wr(1, F_POL, 32'h0000_0020);
        wr(1, F_LEVEL, 32'h0000_0020);
        settle();
        rd(1, F_STATUS, 32'd0, "R9 inactive level");
        pin_in[37] = 1'b1;
        settle();
        rd(1, F_STATUS, 32'h0000_0020, "R9 active high level");
        chk_irq(1'b1, "R10 level irq");
        wr(1, F_STATUS, 32'h0000_0020);
        rd(1, F_STATUS, 32'h0000_0020, "R9 clear blocked while active");
        pin_in[37] = 1'b0;
        settle();
        rd(1, F_STATUS, 32'd0, "R9 drops when inactive");
        chk_irq(1'b0, "R10 level irq gone");
        wr(1, F_POL, 32'd0);
        settle();
        rd(1, F_STATUS, 32'h0000_0020, "R9 active low level");

        settle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule